// File: doc/BRIEF.md
# System Reset Sequencer with Programmer Handshake Pins

The block merges four reset requests into one CPU reset: a power-on request, an active-high external reset pin, a watchdog expiry that only counts once software enables it, and a boot-check failure raised when flash contents read back as invalid. The power-on request also serves as the asynchronous reset of the block. The external, watchdog and boot-check inputs pass through two-flop synchronisers into the system clock domain. A slow sleep clock is synchronised in the same way and edge-detected into a one-cycle tick, and all reset durations are counted in these ticks.

After a power-on or external reset, the block holds the CPU in reset and runs a two-phase drive pattern on two handshake pins. This lets an external programmer find the moment the device comes out of reset. In the first phase, pin 0 drives strong high and pin 1 drives resistive low. In the second phase, both pins drive resistive low. When the second phase ends, both pins float and the CPU is released. A watchdog or boot-check reset skips the pin pattern: the CPU is held for a short fixed tick count while both pins float. Any new request during a hold restarts the hold from its first phase.

The reset cause is kept in two software-visible registers, and each cause bit is cleared by writing 1 to it. Every reset returns all register fields to their default values, including the watchdog enable. The cause of that reset is then set as the only cause bit.

Top module: `reset_sequencer`

## Requirements
- R1: While `por` is high, `cpu_rst` is 1, `pin0_mode` is 2'b01 (strong high), `pin1_mode` is 2'b10 (resistive low), register 0 reads 8'h01 (bit 0 = power-on cause) and register 1 reads 8'h00.
- R2: The first phase, with pin 0 at 2'b01 and pin 1 at 2'b10, lasts PHASE_TICKS sleep ticks. It then moves to the second phase, in which both pins are 2'b10.
- R3: The second phase lasts exactly PHASE_TICKS sleep-clock periods. After it, both pins are 2'b00 (high impedance) and `cpu_rst` is 0.
- R4: A high level on `ext_rst` starts the two-phase sequence from its first phase. It then makes register 0 read 8'h02 (bit 1 = external cause) and register 1 read 8'h00.
- R5: With the watchdog enable (register 0 bit 7) set, a pulse on `wdt_expire` holds `cpu_rst` for about SHORT_TICKS sleep ticks with both pins at 2'b00. It leaves register 0 at 8'h04 (bit 2 = watchdog cause).
- R6: With the watchdog enable clear, `wdt_expire` has no effect: `cpu_rst` stays 0 and both registers keep their values.
- R7: A pulse on `boot_fail` holds `cpu_rst` for about SHORT_TICKS sleep ticks with both pins at 2'b00. It leaves register 1 at 8'h01 (bit 0 = boot-check cause) and register 0 at 8'h00.
- R8: Writing a 1 to a cause bit (register 0 bits 2:0, register 1 bit 0) clears it, and writing a 0 leaves it. Register 0 bit 7 takes the written value.
- R9: A reset request that arrives during the second phase returns the pins to the first-phase pattern, and both phases then run their full length.
- R10: `gpio_hiz` is 1 whenever `cpu_rst` is 1 and for one system cycle after `cpu_rst` falls, and 0 otherwise.
- R11: Every reset clears the watchdog enable, and at most one cause bit is ever set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset request, active high, asynchronous |
| slp_clk | input | 1 | Slow sleep clock that times the reset phases |
| ext_rst | input | 1 | External reset pin, active high |
| wdt_expire | input | 1 | Watchdog expiry request |
| boot_fail | input | 1 | Boot check reports invalid flash reads |
| bus_addr | input | ADDR_W | Register select (0 = cause/control, 1 = boot cause) |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data, combinational from `bus_addr` |
| cpu_rst | output | 1 | CPU reset, active high |
| pin0_mode | output | 2 | Handshake pin 0 drive mode (00 high-Z, 01 strong high, 10 resistive low) |
| pin1_mode | output | 2 | Handshake pin 1 drive mode, same encoding |
| gpio_hiz | output | 1 | Forces all other GPIO pins to high impedance |

## Verification
The bound checker watches invariants on every cycle: the two pins only take legal pairings, and both pins float whenever the CPU runs. The first phase can only move on to the second phase or restart. The phase counter stays in range, and at most one cause bit is set. The watchdog enable is cleared by every reset, a write of 1 clears the power-on cause, and a masked watchdog expiry never resets the CPU. Phase lengths in sleep periods, the restart of a full sequence by a late request, the short hold lengths and the cause values left by each kind of reset depend on whole scenarios. The bench measures and checks these under random request and write mixes.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [1:0] {
    DRV_HIZ       = 2'b00,
    DRV_STRONG_HI = 2'b01,
    DRV_RES_LO    = 2'b10
  } drv_mode_e;

  typedef enum logic [1:0] {
    SQ_HOLD_A = 2'b00,
    SQ_HOLD_B = 2'b01,
    SQ_SHORT  = 2'b10,
    SQ_RUN    = 2'b11
  } seq_st_e;

  // Drive mode of handshake pin 0 for a sequencer state.
  function automatic drv_mode_e pin0_of(input seq_st_e st);
    case (st)
      SQ_HOLD_A: return DRV_STRONG_HI;
      SQ_HOLD_B: return DRV_RES_LO;
      default:   return DRV_HIZ;
    endcase
  endfunction

  // Drive mode of handshake pin 1 for a sequencer state.
  function automatic drv_mode_e pin1_of(input seq_st_e st);
    return (st == SQ_HOLD_A || st == SQ_HOLD_B) ? DRV_RES_LO : DRV_HIZ;
  endfunction

  // True when the tick being counted is the final one of a window.
  function automatic logic window_done(input int unsigned count, input int unsigned limit);
    return (count + 1) == limit;
  endfunction

  // New value of a write-one-to-clear field.
  function automatic logic w1c(input logic cur, input logic hit);
    return cur & ~hit;
  endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or posedge rst) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rstseq_tick.sv
module rstseq_tick #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic slp_clk,
  output logic tick
);
  logic slp_s;
  logic slp_prev;

  rstseq_sync #(.WIDTH(1), .STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (slp_clk),
    .q   (slp_s)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) slp_prev <= 1'b0;
    else     slp_prev <= slp_s;
  end

  assign tick = slp_s & ~slp_prev;
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int PHASE_TICKS = 256,
  parameter int SHORT_TICKS = 16,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             req_long,
  input  logic             req_short,
  output seq_st_e          state,
  output logic [CNT_W-1:0] cnt,
  output logic             cpu_rst,
  output logic [1:0]       pin0_mode,
  output logic [1:0]       pin1_mode,
  output logic             gpio_hiz
);
  seq_st_e st_q;
  logic [CNT_W-1:0] cnt_q;
  logic rst_dly_q;
  logic last_phase;
  logic last_short;

  assign last_phase = window_done(32'(cnt_q), PHASE_TICKS);
  assign last_short = window_done(32'(cnt_q), SHORT_TICKS);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st_q  <= SQ_HOLD_A;
      cnt_q <= '0;
    end else if (req_long) begin
      st_q  <= SQ_HOLD_A;
      cnt_q <= '0;
    end else if (req_short) begin
      st_q  <= SQ_SHORT;
      cnt_q <= '0;
    end else if (tick) begin
      case (st_q)
        SQ_HOLD_A: begin
          if (last_phase) begin
            st_q  <= SQ_HOLD_B;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        SQ_HOLD_B: begin
          if (last_phase) begin
            st_q  <= SQ_RUN;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        SQ_SHORT: begin
          if (last_short) begin
            st_q  <= SQ_RUN;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: cnt_q <= '0;
      endcase
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) rst_dly_q <= 1'b1;
    else     rst_dly_q <= (st_q != SQ_RUN);
  end

  assign state     = st_q;
  assign cnt       = cnt_q;
  assign cpu_rst   = (st_q != SQ_RUN);
  assign pin0_mode = pin0_of(st_q);
  assign pin1_mode = pin1_of(st_q);
  assign gpio_hiz  = cpu_rst | rst_dly_q;
endmodule

// File: rtl/rstseq_regs.sv
module rstseq_regs
  import rstseq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_ext,
  input  logic              evt_wdt,
  input  logic              evt_boot,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_en,
  output logic [3:0]        cause
);
  localparam logic [ADDR_W-1:0] A_MAIN = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_BOOT = ADDR_W'(1);
  localparam int EN_BIT = DATA_W - 1;

  logic c_por, c_ext, c_wdt, c_boot, en_q;
  logic any_evt;

  assign any_evt = evt_ext | evt_wdt | evt_boot;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      c_por  <= 1'b1;
      c_ext  <= 1'b0;
      c_wdt  <= 1'b0;
      c_boot <= 1'b0;
      en_q   <= 1'b0;
    end else if (any_evt) begin
      c_por  <= 1'b0;
      c_ext  <= evt_ext;
      c_wdt  <= ~evt_ext & evt_wdt;
      c_boot <= ~evt_ext & ~evt_wdt & evt_boot;
      en_q   <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == A_MAIN) begin
        c_por <= w1c(c_por, bus_wdata[0]);
        c_ext <= w1c(c_ext, bus_wdata[1]);
        c_wdt <= w1c(c_wdt, bus_wdata[2]);
        en_q  <= bus_wdata[EN_BIT];
      end else if (bus_addr == A_BOOT) begin
        c_boot <= w1c(c_boot, bus_wdata[0]);
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_MAIN) begin
      bus_rdata[0]      = c_por;
      bus_rdata[1]      = c_ext;
      bus_rdata[2]      = c_wdt;
      bus_rdata[EN_BIT] = en_q;
    end else if (bus_addr == A_BOOT) begin
      bus_rdata[0] = c_boot;
    end
  end

  assign wdt_en = en_q;
  assign cause  = {c_boot, c_wdt, c_ext, c_por};
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int PHASE_TICKS = 256,
  parameter int SHORT_TICKS = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              por,
  input  logic              slp_clk,
  input  logic              ext_rst,
  input  logic              wdt_expire,
  input  logic              boot_fail,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cpu_rst,
  output logic [1:0]        pin0_mode,
  output logic [1:0]        pin1_mode,
  output logic              gpio_hiz
);
  localparam int MAX_TICKS = (PHASE_TICKS > SHORT_TICKS) ? PHASE_TICKS : SHORT_TICKS;
  localparam int CNT_W = $clog2(MAX_TICKS) + 1;

  logic tick;
  logic [2:0] src_s;
  logic ext_s, wdt_s, boot_s;
  logic wdt_en;
  logic evt_ext, evt_wdt, evt_boot, evt_any;
  logic [3:0] cause;
  seq_st_e state;
  logic [CNT_W-1:0] phase_cnt;

  rstseq_tick #(.STAGES(SYNC_STAGES)) u_tick (
    .clk     (clk),
    .rst     (por),
    .slp_clk (slp_clk),
    .tick    (tick)
  );

  rstseq_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_src_sync (
    .clk (clk),
    .rst (por),
    .d   ({boot_fail, wdt_expire, ext_rst}),
    .q   (src_s)
  );

  assign ext_s  = src_s[0];
  assign wdt_s  = src_s[1];
  assign boot_s = src_s[2];

  assign evt_ext  = ext_s;
  assign evt_wdt  = wdt_s & wdt_en;
  assign evt_boot = boot_s;
  assign evt_any  = evt_ext | evt_wdt | evt_boot;

  rstseq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (por),
    .evt_ext   (evt_ext),
    .evt_wdt   (evt_wdt),
    .evt_boot  (evt_boot),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wdt_en    (wdt_en),
    .cause     (cause)
  );

  rstseq_fsm #(
    .PHASE_TICKS (PHASE_TICKS),
    .SHORT_TICKS (SHORT_TICKS),
    .CNT_W       (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (por),
    .tick      (tick),
    .req_long  (evt_ext),
    .req_short (evt_wdt | evt_boot),
    .state     (state),
    .cnt       (phase_cnt),
    .cpu_rst   (cpu_rst),
    .pin0_mode (pin0_mode),
    .pin1_mode (pin1_mode),
    .gpio_hiz  (gpio_hiz)
  );
endmodule

// File: rtl/reset_sequencer_checker.sv
module reset_sequencer_checker #(
  parameter int PHASE_TICKS = 256,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int CNT_W = 9
) (
  input logic              clk,
  input logic              por,
  input logic              cpu_rst,
  input logic [1:0]        pin0_mode,
  input logic [1:0]        pin1_mode,
  input logic              gpio_hiz,
  input logic              evt_any,
  input logic              ext_s,
  input logic              wdt_s,
  input logic              boot_s,
  input logic              wdt_en,
  input logic [3:0]        cause,
  input logic [CNT_W-1:0]  phase_cnt,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata
);
  p_hold_pair_r1: assert property (@(posedge clk) disable iff (por)
    (pin0_mode == 2'b01) |-> (pin1_mode == 2'b10 && cpu_rst));

  p_phase_order_r2: assert property (@(posedge clk) disable iff (por)
    (pin0_mode == 2'b01 && !evt_any) |=> (pin0_mode == 2'b01 || pin0_mode == 2'b10));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (por)
    32'(phase_cnt) < PHASE_TICKS);

  p_run_hiz_r3: assert property (@(posedge clk) disable iff (por)
    !cpu_rst |-> (pin0_mode == 2'b00 && pin1_mode == 2'b00));

  p_short_float_r5: assert property (@(posedge clk) disable iff (por)
    (cpu_rst && pin0_mode == 2'b00) |-> (pin1_mode == 2'b00));

  p_wdt_masked_r6: assert property (@(posedge clk) disable iff (por)
    (wdt_s && !wdt_en && !ext_s && !boot_s && !cpu_rst) |=> !cpu_rst);

  p_w1c_por_r8: assert property (@(posedge clk) disable iff (por)
    (bus_wr && bus_addr == '0 && bus_wdata[0] && !evt_any) |=> !cause[0]);

  p_gpio_hold_r10: assert property (@(posedge clk) disable iff (por)
    cpu_rst |-> gpio_hiz);

  p_gpio_tail_r10: assert property (@(posedge clk) disable iff (por)
    $fell(cpu_rst) |-> gpio_hiz);

  p_en_cleared_r11: assert property (@(posedge clk) disable iff (por)
    evt_any |=> !wdt_en);

  p_one_cause_r11: assert property (@(posedge clk) disable iff (por)
    $onehot0(cause));
endmodule

bind reset_sequencer reset_sequencer_checker #(
  .PHASE_TICKS (PHASE_TICKS),
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .CNT_W       (CNT_W)
) u_chk (
  .clk       (clk),
  .por       (por),
  .cpu_rst   (cpu_rst),
  .pin0_mode (pin0_mode),
  .pin1_mode (pin1_mode),
  .gpio_hiz  (gpio_hiz),
  .evt_any   (evt_any),
  .ext_s     (ext_s),
  .wdt_s     (wdt_s),
  .boot_s    (boot_s),
  .wdt_en    (wdt_en),
  .cause     (cause),
  .phase_cnt (phase_cnt),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/reset_sequencer_tb.sv
module reset_sequencer_tb;
  localparam int CLK_PERIOD  = 10;
  localparam int SLP_DIV     = 8;
  localparam int PHASE_TICKS = 256;
  localparam int SHORT_TICKS = 16;

  logic clk = 1'b0;
  logic slp_clk = 1'b0;
  logic por = 1'b1;
  logic ext_rst = 1'b0, wdt_expire = 1'b0, boot_fail = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic cpu_rst, gpio_hiz;
  logic [1:0] pin0_mode, pin1_mode;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] exp_r0, exp_r1;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(CLK_PERIOD*SLP_DIV/2) slp_clk = ~slp_clk;

  reset_sequencer #(.PHASE_TICKS(PHASE_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_dut (
    .clk(clk), .por(por), .slp_clk(slp_clk), .ext_rst(ext_rst),
    .wdt_expire(wdt_expire), .boot_fail(boot_fail), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_rst(cpu_rst), .pin0_mode(pin0_mode), .pin1_mode(pin1_mode),
    .gpio_hiz(gpio_hiz)
  );

  function automatic int phase_cycles(input int ticks);
    return ticks * SLP_DIV;
  endfunction

  function automatic logic [7:0] model_w0(input logic [7:0] old, input logic [7:0] d);
    return {d[7], 4'b0000, old[2:0] & ~d[2:0]};
  endfunction

  function automatic logic [7:0] model_w1(input logic [7:0] old, input logic [7:0] d);
    return {7'b0, old[0] & ~d[0]};
  endfunction

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic check_regs(input string req);
    logic [7:0] v;
    bus_read(2'd0, v); check({req, " reg0"}, 32'(v), 32'(exp_r0));
    bus_read(2'd1, v); check({req, " reg1"}, 32'(v), 32'(exp_r1));
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) ext_rst = 1'b1;
    else if (which == 1) wdt_expire = 1'b1;
    else boot_fail = 1'b1;
    repeat (3) @(negedge clk);
    ext_rst = 1'b0; wdt_expire = 1'b0; boot_fail = 1'b0;
  endtask

  // Measures both hold phases; first-phase start is not tick aligned.
  task automatic measure_long(input string req);
    int c1 = 0;
    int c2 = 0;
    while (pin0_mode != 2'b01) @(negedge clk);
    while (pin0_mode == 2'b01) begin
      if (pin1_mode != 2'b10) c1 = -100000;
      c1++;
      @(negedge clk);
    end
    check({req, " R2 second phase pins"}, {30'd0, pin0_mode} << 2 | 32'(pin1_mode), 32'h0a);
    while (pin0_mode == 2'b10) begin c2++; @(negedge clk); end
    check_range({req, " R2 first phase length"}, c1, phase_cycles(PHASE_TICKS - 1), phase_cycles(PHASE_TICKS) + 8);
    check({req, " R3 second phase length"}, 32'(c2), 32'(phase_cycles(PHASE_TICKS)));
    check({req, " R3 released"}, {29'd0, cpu_rst, pin0_mode}, 32'd0);
    check({req, " R3 pin1 floats"}, 32'(pin1_mode), 32'd0);
    check({req, " R10 gpio tail"}, 32'(gpio_hiz), 32'd1);
    @(negedge clk);
    check({req, " R10 gpio free"}, 32'(gpio_hiz), 32'd0);
  endtask

  task automatic measure_short(input string req);
    int c = 0;
    int guard = 0;
    while (!cpu_rst && guard < 20) begin guard++; @(negedge clk); end
    while (cpu_rst) begin
      if (pin0_mode != 2'b00 || pin1_mode != 2'b00) c = -100000;
      c++;
      @(negedge clk);
    end
    check_range({req, " short hold length"}, c, phase_cycles(SHORT_TICKS - 1), phase_cycles(SHORT_TICKS) + 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 cpu_rst", 32'(cpu_rst), 32'd1);
    check("R1 pin0", 32'(pin0_mode), 32'h1);
    check("R1 pin1", 32'(pin1_mode), 32'h2);
    exp_r0 = 8'h01; exp_r1 = 8'h00;
    check_regs("R1");
    por = 1'b0;
    measure_long("R1 power-on");
    check_regs("R1 after release");

    // R9 restart during second phase, with enable set first (R11)
    bus_write(2'd0, 8'h80);
    exp_r0 = model_w0(exp_r0, 8'h80);
    check_regs("R8 enable write");
    pulse(0);
    while (pin0_mode != 2'b10) @(negedge clk);
    repeat (100) @(negedge clk);
    pulse(0);
    repeat (6) @(negedge clk);
    check("R9 back to first phase", 32'(pin0_mode), 32'h1);
    measure_long("R9 restart");
    exp_r0 = 8'h02; exp_r1 = 8'h00;
    check_regs("R4 R11 external cause, enable cleared");

    // Directed W1C: 0 leaves, 1 clears
    bus_write(2'd0, 8'h00);
    check_regs("R8 write zero");
    bus_write(2'd0, 8'h02);
    exp_r0 = 8'h00;
    check_regs("R8 write one");

    for (int i = 0; i < 10; i++) begin
      int unsigned sel = $urandom % 4;
      logic [7:0] d0 = 8'($urandom) & 8'h7f;
      logic [7:0] d1 = 8'($urandom);
      bus_write(2'd0, d0); exp_r0 = model_w0(exp_r0, d0);
      bus_write(2'd1, d1); exp_r1 = model_w1(exp_r1, d1);
      check_regs("R8 random write");
      case (sel)
        0: begin
          pulse(0);
          measure_long("R4 external");
          exp_r0 = 8'h02; exp_r1 = 8'h00;
          check_regs("R4 cause");
        end
        1: begin
          bus_write(2'd0, 8'h80); exp_r0 = model_w0(exp_r0, 8'h80);
          pulse(1);
          measure_short("R5 watchdog");
          exp_r0 = 8'h04; exp_r1 = 8'h00;
          check_regs("R5 R11 cause");
        end
        2: begin
          int hits = 0;
          pulse(1);
          for (int k = 0; k < 30; k++) begin
            if (cpu_rst) hits++;
            @(negedge clk);
          end
          check("R6 masked watchdog", 32'(hits), 32'd0);
          check_regs("R6 regs kept");
        end
        default: begin
          pulse(2);
          measure_short("R7 boot check");
          exp_r0 = 8'h00; exp_r1 = 8'h01;
          check_regs("R7 cause");
        end
      endcase
    end

    report();
    $finish;
  end
endmodule